// File: doc/BRIEF.md
# Card Data-Phase Flow Sequencer

This block controls the data phase of a memory-card host controller. Once a command has been issued and its response has come back, it decides when block data may move between the card line and the data FIFO. It pauses on FIFO pressure and at block boundaries, waits there for software, and lets software abort the sequence so that a stop command or stop token can follow. It does not serialise data, compute CRC or frame commands.

Software drives it through one 8-bit control register.

| Bit | Name | Effect |
|-----|------|--------|
| 7 | abort | Aborts the sequence. |
| 6 | continue | Continues to the next block (with bit 4). |
| 5 | auto | Selects automatic block stepping. This is the only stored bit. |
| 4 | enable | Starts or resumes transmission. |
| 3:0 | reserved | Read as 0; written values are ignored. |

Bits 7, 6 and 4 act only on the cycle of the write.

A command is presented by a one-cycle `cmd_start` together with its direction and block count. Reads begin moving data as soon as the response arrives. Writes wait for an explicit enable.

In manual mode every block boundary halts the sequencer. In auto mode the blocks run back to back until the programmed count is reached. The sequencer then returns to idle and pulses `done`.

Top module: `cardxfer_seq`

## Requirements
- R1: After reset the block is idle: `xfer_active`=0, `halted`=0, `halt_cause`=0, `abort_pulse`=0, `done`=0 and `ctl_rdata`=0.
- R2: After the response to a write command, no data moves (`xfer_active`=0) until a control write with bit 4 = 1. A control write with bit 4 = 0 has no effect.
- R3: Bit 4 is accepted only in three places: after a write command's response, in a FIFO stall, or at a block boundary (together with bit 6). Anywhere else it is ignored and the state is unchanged.
- R4: After the response to a read command, the block goes active on the next cycle without any control write.
- R5: When active, a write transfer stalls when `fifo_empty`=1 and a read transfer stalls when `fifo_full`=1. A stall gives `halted`=1 and `halt_cause`=1. The opposite flag has no effect. The stall is left only by a control write with bit 4 = 1.
- R6: In manual mode each `blk_done` while active halts with `halt_cause`=2. Only a single control write with both bit 4 and bit 6 set resumes the transfer. Either bit alone is ignored.
- R7: A control write with bit 7 = 1 while a command is in progress aborts it. `abort_pulse` is high for exactly the first cycle, and `halted`=1 with `halt_cause`=3 is held until the next `cmd_start`, which clears it. Bit 7 is ignored when idle.
- R8: In auto mode (bit 5 set before `cmd_start`), blocks pass without halting. After `cmd_blocks` blocks (a count of 0 acts as 1), the block returns to idle with `done` high for one cycle.
- R9: `ctl_rdata` bits 3:0 always read 0. Bit 5 reads back the last written auto bit, and every other bit reads 0.
- R10: Bit 7 takes priority over every other event in the same cycle. `blk_done` takes priority over a FIFO stall condition in the same cycle.
- R11: `cmd_start` is accepted only when idle or aborted. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| cmd_start | input | 1 | One-cycle pulse: a new data command is issued |
| cmd_write | input | 1 | Direction of the command: 1 = write to card, 0 = read |
| cmd_blocks | input | BLK_W | Block count used in auto mode |
| resp_done | input | 1 | One-cycle pulse: command response received |
| blk_done | input | 1 | One-cycle pulse: one block finished on the line |
| fifo_full | input | 1 | Data FIFO full |
| fifo_empty | input | 1 | Data FIFO empty |
| xfer_active | output | 1 | Data may move this cycle |
| halted | output | 1 | Sequencer is held by a stall, a boundary or an abort |
| halt_cause | output | 2 | 0 none, 1 FIFO stall, 2 block boundary, 3 aborted |
| abort_pulse | output | 1 | High in the first cycle of the aborted state |
| done | output | 1 | One-cycle pulse when an auto-mode transfer completes |

## Verification
The bench builds the block with `BLK_W` = 3, so the block count is small enough that every count from 0 to 7 runs in auto mode in both directions, with the completion cycle predicted from the count. The 8-bit control register is small enough to sweep every write value in the idle, stall and boundary states. There the expected next state follows from bits 7, 6 and 4 alone. The remaining cases target the window where the enable bit is accepted, FIFO flags of the wrong direction, same-cycle priority, and commands issued while busy.

// File: rtl/cxs_pkg.sv
package cxs_pkg;

    localparam int CTL_W      = 8;
    localparam int CB_ABORT   = 7;
    localparam int CB_CONT    = 6;
    localparam int CB_AUTO    = 5;
    localparam int CB_ENABLE  = 4;
    localparam logic [CTL_W-1:0] RD_MASK = CTL_W'(1) << CB_AUTO;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_RESP,
        S_ARMED,
        S_RUN,
        S_STALL,
        S_BOUND,
        S_ABORT
    } seq_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_FIFO  = 2'd1,
        CAUSE_BOUND = 2'd2,
        CAUSE_ABORT = 2'd3
    } halt_cause_t;

    typedef struct packed {
        logic abort;
        logic cont;
        logic enable;
    } ctl_req_t;

    function automatic ctl_req_t decode_ctl(input logic wr, input logic [CTL_W-1:0] d);
        ctl_req_t r;
        r.abort  = wr & d[CB_ABORT];
        r.cont   = wr & d[CB_CONT];
        r.enable = wr & d[CB_ENABLE];
        return r;
    endfunction

    function automatic halt_cause_t cause_of(input seq_state_t s);
        case (s)
            S_STALL: return CAUSE_FIFO;
            S_BOUND: return CAUSE_BOUND;
            S_ABORT: return CAUSE_ABORT;
            default: return CAUSE_NONE;
        endcase
    endfunction

    function automatic logic is_busy(input seq_state_t s);
        return (s != S_IDLE) && (s != S_ABORT);
    endfunction

endpackage

// File: rtl/cxs_ctl_regs.sv
module cxs_ctl_regs
    import cxs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output ctl_req_t         req,
    output logic             auto_mode,
    output logic [CTL_W-1:0] ctl_rdata
);

    logic [CTL_W-1:0] ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q <= ctl_wdata;
        end
    end

    always_comb begin
        req       = decode_ctl(ctl_wr, ctl_wdata);
        auto_mode = ctl_q[CB_AUTO];
        ctl_rdata = ctl_q & RD_MASK;
    end

endmodule

// File: rtl/cxs_blk_counter.sv
module cxs_blk_counter #(
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [BLK_W-1:0] total_in,
    input  logic             inc,
    output logic             last
);

    localparam int CW = BLK_W + 1;

    logic [BLK_W-1:0] cnt_q;
    logic [BLK_W-1:0] total_q;
    logic [CW-1:0]    next_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            total_q <= '0;
        end else if (load) begin
            cnt_q   <= '0;
            total_q <= total_in;
        end else if (inc) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        next_cnt = {1'b0, cnt_q} + CW'(1);
        last     = next_cnt >= {1'b0, total_q};
    end

endmodule

// File: rtl/cxs_fsm.sv
module cxs_fsm
    import cxs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctl_req_t   req,
    input  logic       auto_mode,
    input  logic       cmd_start,
    input  logic       cmd_write,
    input  logic       resp_done,
    input  logic       blk_done,
    input  logic       fifo_full,
    input  logic       fifo_empty,
    input  logic       blk_last,
    output logic       cnt_load,
    output logic       cnt_inc,
    output seq_state_t state,
    output logic       dir_w,
    output logic       abort_pulse,
    output logic       done
);

    seq_state_t state_q, state_d;
    logic       dir_q, auto_q;
    logic       abort_take, fifo_stall;
    logic       done_d;

    always_comb begin
        abort_take = req.abort && is_busy(state_q);
        fifo_stall = dir_q ? fifo_empty : fifo_full;
        cnt_load   = !abort_take && !is_busy(state_q) && cmd_start;
        cnt_inc    = !abort_take && (state_q == S_RUN) && blk_done;
        state_d    = state_q;
        done_d     = 1'b0;
        if (abort_take) begin
            state_d = S_ABORT;
        end else begin
            case (state_q)
                S_IDLE, S_ABORT: if (cmd_start) state_d = S_WAIT_RESP;
                S_WAIT_RESP:     if (resp_done) state_d = dir_q ? S_ARMED : S_RUN;
                S_ARMED:         if (req.enable) state_d = S_RUN;
                S_RUN: begin
                    if (blk_done) begin
                        if (auto_q && blk_last) begin
                            state_d = S_IDLE;
                            done_d  = 1'b1;
                        end else if (!auto_q) begin
                            state_d = S_BOUND;
                        end
                    end else if (fifo_stall) begin
                        state_d = S_STALL;
                    end
                end
                S_STALL:         if (req.enable) state_d = S_RUN;
                S_BOUND:         if (req.enable && req.cont) state_d = S_RUN;
                default:         state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            dir_q       <= 1'b0;
            auto_q      <= 1'b0;
            abort_pulse <= 1'b0;
            done        <= 1'b0;
        end else begin
            state_q     <= state_d;
            abort_pulse <= abort_take;
            done        <= done_d;
            if (cnt_load) begin
                dir_q  <= cmd_write;
                auto_q <= auto_mode;
            end
        end
    end

    assign state = state_q;
    assign dir_w = dir_q;

endmodule

// File: rtl/cxs_status.sv
module cxs_status
    import cxs_pkg::*;
(
    input  seq_state_t  state,
    output logic        xfer_active,
    output logic        halted,
    output logic [1:0]  halt_cause
);

    halt_cause_t cause;

    always_comb begin
        cause       = cause_of(state);
        xfer_active = (state == S_RUN);
        halted      = (cause != CAUSE_NONE);
        halt_cause  = cause;
    end

endmodule

// File: rtl/cardxfer_seq.sv
module cardxfer_seq
    import cxs_pkg::*;
#(
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             cmd_start,
    input  logic             cmd_write,
    input  logic [BLK_W-1:0] cmd_blocks,
    input  logic             resp_done,
    input  logic             blk_done,
    input  logic             fifo_full,
    input  logic             fifo_empty,
    output logic             xfer_active,
    output logic             halted,
    output logic [1:0]       halt_cause,
    output logic             abort_pulse,
    output logic             done
);

    ctl_req_t   req;
    logic       auto_mode;
    logic       blk_last, cnt_load, cnt_inc;
    logic       dir_w;
    seq_state_t state;

    cxs_ctl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .req       (req),
        .auto_mode (auto_mode),
        .ctl_rdata (ctl_rdata)
    );

    cxs_blk_counter #(.BLK_W(BLK_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .total_in (cmd_blocks),
        .inc      (cnt_inc),
        .last     (blk_last)
    );

    cxs_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .auto_mode   (auto_mode),
        .cmd_start   (cmd_start),
        .cmd_write   (cmd_write),
        .resp_done   (resp_done),
        .blk_done    (blk_done),
        .fifo_full   (fifo_full),
        .fifo_empty  (fifo_empty),
        .blk_last    (blk_last),
        .cnt_load    (cnt_load),
        .cnt_inc     (cnt_inc),
        .state       (state),
        .dir_w       (dir_w),
        .abort_pulse (abort_pulse),
        .done        (done)
    );

    cxs_status u_stat (
        .state       (state),
        .xfer_active (xfer_active),
        .halted      (halted),
        .halt_cause  (halt_cause)
    );

endmodule

// File: rtl/cxs_checker.sv
module cxs_checker (
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr,
    input logic [7:0] ctl_wdata,
    input logic       dir_w,
    input logic       xfer_active,
    input logic       halted,
    input logic [1:0] halt_cause,
    input logic       abort_pulse,
    input logic       done
);

    // R2: a write transfer only starts or resumes on an enable write
    p_write_needs_enable_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(xfer_active) && dir_w) |-> $past(ctl_wr && ctl_wdata[4]));

    // R5: a FIFO stall holds until enable or abort
    p_stall_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (halt_cause == 2'd1 && !(ctl_wr && (ctl_wdata[4] || ctl_wdata[7])))
        |=> (halt_cause == 2'd1));

    // R6: a boundary holds unless continue+enable or abort
    p_boundary_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (halt_cause == 2'd2 && !(ctl_wr && ((ctl_wdata[4] && ctl_wdata[6]) || ctl_wdata[7])))
        |=> (halt_cause == 2'd2));

    // R7: abort pulse is a single cycle inside the aborted state
    p_abort_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> (halted && halt_cause == 2'd3));

    p_abort_single_r7: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |=> !abort_pulse);

    // R8: completion returns to idle with no halt
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!xfer_active && !halted));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: active never coexists with a halt
    p_active_not_halted_r5: assert property (@(posedge clk) disable iff (rst)
        xfer_active |-> !halted);

endmodule

bind cardxfer_seq cxs_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (ctl_wdata),
    .dir_w       (dir_w),
    .xfer_active (xfer_active),
    .halted      (halted),
    .halt_cause  (halt_cause),
    .abort_pulse (abort_pulse),
    .done        (done)
);

// File: tb/cardxfer_seq_bench.sv
`timescale 1ns/1ps
module cardxfer_seq_bench;

    localparam int BW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctl_wr = 1'b0;
    logic [7:0]    ctl_wdata = '0;
    logic [7:0]    ctl_rdata;
    logic          cmd_start = 1'b0;
    logic          cmd_write = 1'b0;
    logic [BW-1:0] cmd_blocks = '0;
    logic          resp_done = 1'b0;
    logic          blk_done = 1'b0;
    logic          fifo_full = 1'b0;
    logic          fifo_empty = 1'b0;
    logic          xfer_active, halted, abort_pulse, done;
    logic [1:0]    halt_cause;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cardxfer_seq #(.BLK_W(BW)) u_cardxfer_seq (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .cmd_start(cmd_start), .cmd_write(cmd_write),
        .cmd_blocks(cmd_blocks), .resp_done(resp_done), .blk_done(blk_done),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .xfer_active(xfer_active), .halted(halted), .halt_cause(halt_cause),
        .abort_pulse(abort_pulse), .done(done)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        step();
        ctl_wr = 1'b0; ctl_wdata = '0;
    endtask

    task automatic cmd(input logic w, input int n);
        cmd_start = 1'b1; cmd_write = w; cmd_blocks = BW'(n);
        step();
        cmd_start = 1'b0;
    endtask

    task automatic resp();
        resp_done = 1'b1; step(); resp_done = 1'b0;
    endtask

    task automatic blk();
        blk_done = 1'b1; step(); blk_done = 1'b0;
    endtask

    // leave any transfer: abort if busy (ignored when idle/aborted)
    task automatic clear_to_free();
        wr(8'h80);
        wr(8'h00);
    endtask

    // expected status as a single code: 4 = active, else halt cause
    function automatic int status_code();
        return xfer_active ? 4 : int'(halt_cause);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1", "active", xfer_active, 0);
        chk("R1", "halted", halted, 0);
        chk("R1", "cause", halt_cause, 0);
        chk("R1", "abort", abort_pulse, 0);
        chk("R1", "done", done, 0);
        chk("R1", "rdata", ctl_rdata, 0);

        // R9 / R3 / R7: sweep every control value while idle
        for (int v = 0; v < 256; v++) begin
            wr(8'(v));
            chk("R9", "rdata", ctl_rdata, (v & 32));
            chk("R3", "idle status", status_code(), 0);
        end

        // R2 / R3 write command arming
        wr(8'h00);
        cmd(1'b1, 3);
        wr(8'h10);
        chk("R3", "enable before response", status_code(), 0);
        resp();
        chk("R2", "armed not active", xfer_active, 0);
        wr(8'h00);
        chk("R2", "enable=0 no effect", xfer_active, 0);
        wr(8'h10);
        chk("R2", "enable starts", xfer_active, 1);
        wr(8'h10);
        chk("R3", "enable while active", status_code(), 4);

        // R5 write direction: full ignored, empty stalls
        fifo_full = 1'b1; step(); fifo_full = 1'b0;
        chk("R5", "write ignores full", status_code(), 4);
        fifo_empty = 1'b1; step(); fifo_empty = 1'b0;
        chk("R5", "write stall", status_code(), 1);
        repeat (3) step();
        chk("R5", "stall holds", status_code(), 1);
        wr(8'h40);
        chk("R5", "continue alone no resume", status_code(), 1);
        wr(8'h10);
        chk("R5", "enable resumes", status_code(), 4);

        // R10: block end beats fifo stall in the same cycle
        blk_done = 1'b1; fifo_empty = 1'b1; step(); blk_done = 1'b0; fifo_empty = 1'b0;
        chk("R10", "boundary over stall", status_code(), 2);
        // R10: abort beats continue
        wr(8'hD0);
        chk("R10", "abort priority", status_code(), 3);
        chk("R7", "abort pulse", abort_pulse, 1);
        step();
        chk("R7", "pulse one cycle", abort_pulse, 0);
        chk("R7", "abort held", status_code(), 3);
        wr(8'h80);
        chk("R7", "abort in aborted no repulse", abort_pulse, 0);
        cmd(1'b0, 2);
        chk("R7", "new cmd clears abort", status_code(), 0);
        chk("R7", "halted clear", halted, 0);

        // R4 read starts on response; R11 cmd while busy ignored
        resp();
        chk("R4", "read active", status_code(), 4);
        fifo_empty = 1'b1; step(); fifo_empty = 1'b0;
        chk("R5", "read ignores empty", status_code(), 4);
        cmd(1'b1, 1);
        chk("R11", "cmd while busy", status_code(), 4);
        fifo_full = 1'b1; step(); fifo_full = 1'b0;
        chk("R11", "direction kept read", status_code(), 1);
        clear_to_free();

        // R6 sweep at a boundary
        for (int v = 0; v < 256; v++) begin
            clear_to_free();
            cmd(1'b0, 3);
            resp();
            blk();
            chk("R6", "at boundary", status_code(), 2);
            wr(8'(v));
            if (v & 128) begin
                chk("R7", "boundary abort", status_code(), 3);
                chk("R7", "boundary pulse", abort_pulse, 1);
            end else if ((v & 16) && (v & 64)) begin
                chk("R6", "continue", status_code(), 4);
            end else begin
                chk("R6", "hold", status_code(), 2);
            end
        end

        // R5 sweep in a read stall
        for (int v = 0; v < 256; v++) begin
            clear_to_free();
            cmd(1'b0, 3);
            resp();
            fifo_full = 1'b1; step(); fifo_full = 1'b0;
            wr(8'(v));
            if (v & 128)     chk("R7", "stall abort", status_code(), 3);
            else if (v & 16) chk("R5", "stall resume", status_code(), 4);
            else             chk("R5", "stall hold", status_code(), 1);
        end

        // R8 auto mode: every count, both directions
        for (int d = 0; d < 2; d++) begin
            for (int n = 0; n < (1 << BW); n++) begin
                int nb;
                nb = (n == 0) ? 1 : n;
                clear_to_free();
                wr(8'h20);
                cmd(d[0], n);
                resp();
                if (d == 1) wr(8'h10);
                chk("R8", "auto running", status_code(), 4);
                for (int k = 1; k <= nb; k++) begin
                    blk();
                    if (k < nb) begin
                        chk("R8", "auto no halt", status_code(), 4);
                        chk("R8", "no early done", done, 0);
                    end else begin
                        chk("R8", "done pulse", done, 1);
                        chk("R8", "idle after", status_code(), 0);
                    end
                end
                step();
                chk("R8", "done one cycle", done, 0);
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule